// File: doc/BRIEF.md
# Neighbour Latch Enable Ordering Monitor

This block is a synthesizable run-time checker for one pair of neighbouring latch enables in a pipeline that has had its global clock replaced by local handshaking controllers. One enable drives the upstream latch and the other drives the downstream latch. The monitor samples both enables with a fast observation clock through synchronizer chains. It detects every rising and falling edge and replays those edges against a six-arc token marking of the allowed ordering.

A fired edge consumes a token from each of its incoming arcs and deposits one on each of its outgoing arcs. An edge whose incoming arcs are not all marked is a protocol breach. The monitor then latches a violation flag and a code naming the offending edge, and freezes its marking until reset. The marking permits the two falls to happen in either order, so every legal interleaving passes. Any sequence that lets the upstream latch capture a second value before the downstream latch took the first one is caught. A single input selects which physical enable is treated as upstream, so one monitor design serves both odd-to-even and even-to-odd pairs. A saturating counter reports how many edges were accepted since reset.

Top module: `lcp_monitor`

## Requirements
- R1: While reset (synchronous, active high) is asserted and afterwards until an edge is seen, the violation flag is 0, the code is 0 and the event count is 0. Reset restores the initial marking, in which the upstream rise is enabled and nothing else is.
- R2: From the initial marking, the order upstream rise, upstream fall, downstream rise, downstream fall is accepted without a flag. Each edge adds one to the count.
- R3: The order upstream rise, downstream rise, downstream fall, upstream fall is accepted without a flag.
- R4: The order upstream rise, downstream rise, upstream fall, downstream fall is accepted without a flag.
- R5: Upstream rise, upstream fall, then a second upstream rise before any downstream rise sets the flag with code 1. The codes are 1 upstream rise, 2 upstream fall, 3 downstream rise and 4 downstream fall.
- R6: A downstream rise from the initial marking, before any upstream rise, sets the flag with code 3.
- R7: Once set, the flag and the code hold their values until reset. Later edges change neither the flag, the code nor the count.
- R8: The count increments once per accepted edge and saturates at 2^CNT_W-1 instead of wrapping.
- R9: With the orientation input at 1, the even enable is upstream and the odd enable is downstream. With it at 0, the odd enable is upstream.
- R10: An upstream rise and a downstream rise seen in the same sample are processed upstream first. From a marking where the upstream rise is enabled, both are accepted and the count grows by 2.
- R11: Both falls seen in the same sample are accepted in either order, and the count grows by 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Observation clock, much faster than the enables |
| rst | input | 1 | Synchronous active-high reset |
| odd_en | input | 1 | Enable of the odd latch (asynchronous to clk) |
| even_en | input | 1 | Enable of the even latch (asynchronous to clk) |
| even_upstream | input | 1 | 1: even enable is upstream; 0: odd enable is upstream |
| viol | output | 1 | Sticky protocol violation flag |
| viol_code | output | 3 | Edge that fired while not enabled (1..4), 0 when no violation |
| evt_count | output | CNT_W | Saturating count of accepted edges since reset |

## Verification
The bench builds the monitor with CNT_W set to 4, so the count saturates at 15. One pass through the three legal orderings, plus one pair of coincident rises and one pair of coincident falls, then drives the counter into saturation. That exercises the ceiling without tens of thousands of edges. SYNC_STAGES keeps its default of 2. Each bench step holds its inputs long enough for the edge to cross the synchronizer and the marking register before the outputs are compared.

// File: rtl/lcp_pkg.sv
package lcp_pkg;

   // Tokens on the six arcs of the ordering graph.
   // uu: up+ -> up-   dd: dn+ -> dn-   ud: up+ -> dn+
   // du: dn+ -> up+   uf: up- -> up+   df: dn- -> dn+
   typedef struct packed {
      logic uu;
      logic dd;
      logic ud;
      logic du;
      logic uf;
      logic df;
   } mark_t;

   localparam mark_t MARK_INIT = '{uu: 1'b0, dd: 1'b0, ud: 1'b0,
                                   du: 1'b1, uf: 1'b1, df: 1'b1};

   localparam int CODE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      EV_NONE    = 3'd0,
      EV_UP_RISE = 3'd1,
      EV_UP_FALL = 3'd2,
      EV_DN_RISE = 3'd3,
      EV_DN_FALL = 3'd4
   } ev_code_e;

   // Processing order inside one sample: up+, dn+, up-, dn-
   localparam int N_EV = 4;

   function automatic ev_code_e code_at(input int slot);
      case (slot)
         0:       return EV_UP_RISE;
         1:       return EV_DN_RISE;
         2:       return EV_UP_FALL;
         default: return EV_DN_FALL;
      endcase
   endfunction

   function automatic logic ev_enabled(input mark_t m, input ev_code_e ev);
      case (ev)
         EV_UP_RISE: return m.du & m.uf;
         EV_UP_FALL: return m.uu;
         EV_DN_RISE: return m.ud & m.df;
         EV_DN_FALL: return m.dd;
         default:    return 1'b0;
      endcase
   endfunction

   function automatic mark_t ev_fire(input mark_t m, input ev_code_e ev);
      mark_t r;
      r = m;
      case (ev)
         EV_UP_RISE: begin r.du = 1'b0; r.uf = 1'b0; r.uu = 1'b1; r.ud = 1'b1; end
         EV_UP_FALL: begin r.uu = 1'b0; r.uf = 1'b1; end
         EV_DN_RISE: begin r.ud = 1'b0; r.df = 1'b0; r.dd = 1'b1; r.du = 1'b1; end
         EV_DN_FALL: begin r.dd = 1'b0; r.df = 1'b1; end
         default:    r = m;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/lcp_edge_sync.sv
module lcp_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic level,
   output logic rise,
   output logic fall
);

   localparam int CHAIN_W = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

   if (SYNC_STAGES < 1) begin : g_bad_stages
      $error("lcp_edge_sync: SYNC_STAGES must be at least 1");
   end

   logic [CHAIN_W-1:0] chain_q;
   logic               prev_q;

   if (CHAIN_W == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (rst) chain_q <= '0;
         else     chain_q <= async_in;
      end
   end else begin : g_multi
      always_ff @(posedge clk) begin
         if (rst) chain_q <= '0;
         else     chain_q <= {chain_q[CHAIN_W-2:0], async_in};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= chain_q[CHAIN_W-1];
   end

   assign level = chain_q[CHAIN_W-1];
   assign rise  = level & ~prev_q;
   assign fall  = ~level & prev_q;

endmodule

// File: rtl/lcp_marking.sv
module lcp_marking
   import lcp_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              up_rise,
   input  logic              up_fall,
   input  logic              dn_rise,
   input  logic              dn_fall,
   output logic              viol,
   output logic [CODE_W-1:0] viol_code,
   output logic [2:0]        n_accept
);

   mark_t            mark_q, mark_d;
   logic             viol_q;
   ev_code_e         code_q, code_d;
   logic             hit_d;
   logic [2:0]       n_d;
   logic [N_EV-1:0]  ev_v;

   assign ev_v = {dn_fall, up_fall, dn_rise, up_rise};

   always_comb begin
      mark_t m;
      logic  stop;
      m      = mark_q;
      stop   = 1'b0;
      hit_d  = 1'b0;
      code_d = EV_NONE;
      n_d    = '0;
      for (int i = 0; i < N_EV; i++) begin
         if (!stop && ev_v[i]) begin
            if (ev_enabled(m, code_at(i))) begin
               m   = ev_fire(m, code_at(i));
               n_d = n_d + 3'd1;
            end else begin
               stop   = 1'b1;
               hit_d  = 1'b1;
               code_d = code_at(i);
            end
         end
      end
      mark_d = m;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mark_q <= MARK_INIT;
         viol_q <= 1'b0;
         code_q <= EV_NONE;
      end else if (!viol_q) begin
         mark_q <= mark_d;
         if (hit_d) begin
            viol_q <= 1'b1;
            code_q <= code_d;
         end
      end
   end

   assign viol      = viol_q;
   assign viol_code = code_q;
   assign n_accept  = viol_q ? 3'd0 : n_d;

   // Each cycle in the graph keeps exactly one token.
   AST_UP_RING_ONE: assert property (@(posedge clk) disable iff (rst)
      $countones({mark_q.uu, mark_q.uf}) == 1);                          // R1
   AST_DN_RING_ONE: assert property (@(posedge clk) disable iff (rst)
      $countones({mark_q.dd, mark_q.df}) == 1);                          // R1
   AST_CROSS_RING_ONE: assert property (@(posedge clk) disable iff (rst)
      $countones({mark_q.ud, mark_q.du}) == 1);                          // R5
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      viol_q |=> viol_q);                                                // R7
   AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
      viol_q |=> $stable(code_q));                                       // R7
   AST_MARK_FROZEN: assert property (@(posedge clk) disable iff (rst)
      viol_q |=> $stable(mark_q));                                       // R7
   AST_CODE_VALID: assert property (@(posedge clk) disable iff (rst)
      viol_q |-> (code_q != EV_NONE));                                   // R5

endmodule

// File: rtl/lcp_sat_counter.sv
module lcp_sat_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [2:0]       inc,
   output logic [CNT_W-1:0] count
);

   localparam int SUM_W = CNT_W + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 3) begin : g_bad_width
      $error("lcp_sat_counter: CNT_W must be at least 3");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [SUM_W-1:0] sum;

   assign sum = {1'b0, cnt_q} + SUM_W'(inc);

   always_ff @(posedge clk) begin
      if (rst)                cnt_q <= '0;
      else if (sum[CNT_W])    cnt_q <= CNT_MAX;
      else                    cnt_q <= sum[CNT_W-1:0];
   end

   assign count = cnt_q;

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));                        // R8
   AST_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
      ##1 (cnt_q >= $past(cnt_q)));                                      // R8

endmodule

// File: rtl/lcp_monitor.sv
module lcp_monitor
   import lcp_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 odd_en,
   input  logic                 even_en,
   input  logic                 even_upstream,
   output logic                 viol,
   output logic [CODE_W-1:0]    viol_code,
   output logic [CNT_W-1:0]     evt_count
);

   localparam int N_CH = 2;   // channel 0 = odd, channel 1 = even

   logic [N_CH-1:0] raw_en, lvl, rise, fall;
   logic            up_rise, up_fall, dn_rise, dn_fall;
   logic [2:0]      n_accept;

   assign raw_en = {even_en, odd_en};

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      lcp_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
         .clk      (clk),
         .rst      (rst),
         .async_in (raw_en[c]),
         .level    (lvl[c]),
         .rise     (rise[c]),
         .fall     (fall[c])
      );
   end

   // Orientation picks which channel plays the upstream role.
   assign up_rise = even_upstream ? rise[1] : rise[0];
   assign up_fall = even_upstream ? fall[1] : fall[0];
   assign dn_rise = even_upstream ? rise[0] : rise[1];
   assign dn_fall = even_upstream ? fall[0] : fall[1];

   lcp_marking u_mark (
      .clk       (clk),
      .rst       (rst),
      .up_rise   (up_rise),
      .up_fall   (up_fall),
      .dn_rise   (dn_rise),
      .dn_fall   (dn_fall),
      .viol      (viol),
      .viol_code (viol_code),
      .n_accept  (n_accept)
   );

   lcp_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (n_accept),
      .count (evt_count)
   );

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!viol && viol_code == '0 && evt_count == '0));            // R1
   AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (rst)
      viol |=> $stable(evt_count));                                      // R7
   AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(up_rise && up_fall) && !(dn_rise && dn_fall));                   // R9

endmodule

// File: tb/lcp_monitor_test.sv
module lcp_monitor_test;

   localparam int CNT_W = 4;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             odd_en = 1'b0;
   logic             even_en = 1'b0;
   logic             even_upstream = 1'b0;
   logic             viol;
   logic [2:0]       viol_code;
   logic [CNT_W-1:0] evt_count;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   typedef struct {
      logic       v;
      logic [2:0] code;
      int         cnt;
      string      req;
   } exp_t;

   exp_t sb_q[$];

   always #2 clk = ~clk;   // 250 MHz

   lcp_monitor #(.SYNC_STAGES(2), .CNT_W(CNT_W)) uut (
      .clk           (clk),
      .rst           (rst),
      .odd_en        (odd_en),
      .even_en       (even_en),
      .even_upstream (even_upstream),
      .viol          (viol),
      .viol_code     (viol_code),
      .evt_count     (evt_count)
   );

   // Monitor: pops expected items and compares them away from the active edge.
   initial begin
      forever begin
         @(negedge clk);
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            total++;
            if (viol !== e.v || viol_code !== e.code || int'(evt_count) != e.cnt) begin
               bad++;
               $display("FAIL %s: got viol=%0b code=%0d cnt=%0d, expected viol=%0b code=%0d cnt=%0d",
                        e.req, viol, viol_code, evt_count, e.v, e.code, e.cnt);
            end
         end
      end
   end

   task automatic expect_now(input logic v, input logic [2:0] code, input int cnt,
                             input string req);
      exp_t e;
      e.v = v; e.code = code; e.cnt = cnt; e.req = req;
      sb_q.push_back(e);
      @(negedge clk);
   endtask

   // Driver: apply a level pair, let it cross sync + marking, queue the expectation.
   task automatic step(input logic o, input logic e, input logic v, input logic [2:0] code,
                       input int cnt, input string req);
      @(negedge clk);
      odd_en  = o;
      even_en = e;
      repeat (5) @(posedge clk);
      expect_now(v, code, cnt, req);
   endtask

   task automatic do_reset(input logic orient);
      @(negedge clk);
      rst = 1'b1;
      odd_en = 1'b0;
      even_en = 1'b0;
      even_upstream = orient;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      repeat (3) @(posedge clk);
      expect_now(1'b0, 3'd0, 0, "R1 reset state");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      do_reset(1'b0);

      // R2: up+ up- dn+ dn-
      step(1, 0, 0, 0, 1, "R2 up+");
      step(0, 0, 0, 0, 2, "R2 up-");
      step(0, 1, 0, 0, 3, "R2 dn+");
      step(0, 0, 0, 0, 4, "R2 dn-");
      // R3: up+ dn+ dn- up-
      step(1, 0, 0, 0, 5, "R3 up+");
      step(1, 1, 0, 0, 6, "R3 dn+");
      step(1, 0, 0, 0, 7, "R3 dn-");
      step(0, 0, 0, 0, 8, "R3 up-");
      // R4: up+ dn+ up- dn-
      step(1, 0, 0, 0, 9,  "R4 up+");
      step(1, 1, 0, 0, 10, "R4 dn+");
      step(0, 1, 0, 0, 11, "R4 up-");
      step(0, 0, 0, 0, 12, "R4 dn-");
      // R10 coincident rises, R11 coincident falls, R8 saturation at 15
      step(1, 1, 0, 0, 14, "R10 both rise");
      step(0, 0, 0, 0, 15, "R11 R8 both fall saturate");
      // R5: second upstream rise before downstream rise
      step(1, 0, 0, 0, 15, "R5 up+ (saturated)");
      step(0, 0, 0, 0, 15, "R5 up-");
      step(1, 0, 1, 1, 15, "R5 second up+");
      // R7: stays flagged
      step(1, 1, 1, 1, 15, "R7 after violation dn+");
      step(0, 0, 1, 1, 15, "R7 after violation falls");

      // R6: downstream rise first
      do_reset(1'b0);
      step(0, 1, 1, 3, 0, "R6 dn+ before up+");
      step(0, 0, 1, 3, 0, "R7 count frozen");
      step(1, 0, 1, 3, 0, "R7 up+ ignored");

      // R9: even upstream
      do_reset(1'b1);
      step(0, 1, 0, 0, 1, "R9 even up+");
      step(0, 0, 0, 0, 2, "R9 even up-");
      step(1, 0, 0, 0, 3, "R9 odd dn+");
      step(0, 0, 0, 0, 4, "R9 odd dn-");
      step(1, 0, 1, 3, 4, "R9 odd dn+ early");

      repeat (4) @(negedge clk);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule